// File: doc/BRIEF.md
# 8-bit Accumulator ALU Slice with Decimal Add

This block is the arithmetic and logic slice of a small 8-bit accumulator machine. Each cycle it takes the current accumulator value and a memory operand, together with the incoming carry and a decimal-mode flag. It then forms one of three results: an add that always includes the carry, a bitwise AND, or a one-bit logical left shift. When the enable strobe is high, the result and the negative (N), overflow (V), zero (Z) and carry (C) flags are written into registers on the rising clock edge.

The add works in two modes. In binary mode it is a plain 8-bit sum with carry. In decimal mode each operand is read as two packed BCD digits, and the sum is corrected digit by digit, so that the register holds a packed BCD value and carry shows that the decimal total went past 99. Each operation writes only its own subset of flags. The flags it does not touch keep their registered values. A fourth select code holds all state.

There is no state machine: the operation select is an enumerated type, decoded with a unique case in one combinational process, and a separate process holds the result and flag registers.

Top module: `alu8_core`

## Requirements
- R1: With op_sel = 2'b00 (add) and dec_mode low, acc_q becomes the low 8 bits of acc_in + mem_in + carry_in. c_q becomes 1 exactly when that unmasked sum exceeds 255.
- R2: For the add (op_sel = 2'b00), v_q becomes bit 7 of (~(A ^ M) & (A ^ S)). Here S is the 8-bit binary sum A + M + carry_in, and this rule applies in both modes.
- R3: With op_sel = 2'b00 and dec_mode high, and both operands valid packed BCD, acc_q becomes the packed BCD form of (decimal total mod 100). c_q becomes 1 exactly when the decimal total exceeds 99.
- R4: For the add, AND and shift, z_q is 1 exactly when the new 8-bit acc_q is zero, and n_q equals bit 7 of the new acc_q. In decimal mode this is the corrected value.
- R5: With op_sel = 2'b01, acc_q becomes acc_in & mem_in, N and Z are updated per R4, and c_q and v_q keep their previous values.
- R6: With op_sel = 2'b10, c_q takes acc_in[7] and acc_q becomes {acc_in[6:0], 0}. The old sign bit is not kept, N and Z follow R4, and v_q keeps its previous value.
- R7: With op_sel = 2'b11 and enable high, acc_q and all four flags keep their values.
- R8: With enable low, acc_q and all four flags keep their values, whatever the other inputs are.
- R9: A high rst at a rising edge clears acc_q and all four flags to 0. This takes priority over enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Update strobe for accumulator and flags |
| op_sel | input | 2 | 00 add, 01 AND, 10 shift left, 11 hold |
| acc_in | input | 8 | Accumulator operand |
| mem_in | input | 8 | Memory operand |
| carry_in | input | 1 | Incoming carry for the add |
| dec_mode | input | 1 | High selects packed BCD add |
| acc_q | output | 8 | Registered result |
| n_q | output | 1 | Registered negative flag |
| v_q | output | 1 | Registered overflow flag |
| z_q | output | 1 | Registered zero flag |
| c_q | output | 1 | Registered carry flag |

## Verification
Binary adds are tried with same-sign operands whose sum changes sign (0x50 + 0x50), to separate true overflow from a plain carry. They are also tried with 0xFF + 0x00 + carry, which wraps to zero and so exercises carry and zero together. Decimal adds cover 0x99 + 0x01 and 0x45 + 0x55, where both digits need correction and the result is zero with carry. They also cover 0x09 + 0x01, where only the low digit needs correction. The AND and shift cases come straight after adds that set carry and overflow, so that a flag that was wrongly written shows up. Random valid-BCD and binary traffic with random enables, hold codes and a mid-run reset is then compared each clock against a reference model built on integer decimal arithmetic.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [1:0] {
        OP_ADD   = 2'b00,
        OP_AND   = 2'b01,
        OP_SHL   = 2'b10,
        OP_HOLD  = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } alu_flags_t;

    localparam int NIBBLE_W = 4;

endpackage

// File: rtl/alu8_adder.sv
module alu8_adder
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    input  logic              dec_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o,
    output logic              ovf_o
);

    localparam int DIGITS = DATA_W / NIBBLE_W;

    logic [DIGITS:0]  dcarry;
    logic [DATA_W:0]  bin_sum;

    assign dcarry[0] = cin_i;

    // One digit stage per nibble; in binary mode the chain is a plain ripple.
    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [NIBBLE_W+1:0] raw;
        logic [NIBBLE_W+1:0] fixed;
        logic                too_big;

        always_comb begin
            raw     = {2'b00, a_i[g*NIBBLE_W +: NIBBLE_W]}
                    + {2'b00, b_i[g*NIBBLE_W +: NIBBLE_W]}
                    + {{(NIBBLE_W+1){1'b0}}, dcarry[g]};
            too_big = (raw > 6'd9);
            if (dec_i && too_big) begin
                fixed = raw + 6'd6;
            end else begin
                fixed = raw;
            end
        end

        assign sum_o[g*NIBBLE_W +: NIBBLE_W] = fixed[NIBBLE_W-1:0];
        assign dcarry[g+1] = dec_i ? too_big : raw[NIBBLE_W];
    end

    assign cout_o = dcarry[DIGITS];

    // Overflow is always judged on the uncorrected binary sum.
    assign bin_sum = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
    assign ovf_o   = ~(a_i[DATA_W-1] ^ b_i[DATA_W-1])
                   &  (a_i[DATA_W-1] ^ bin_sum[DATA_W-1]);

    // R3: valid BCD operands must give valid BCD digits
    always_comb begin
        logic ok_in;
        logic ok_out;
        ok_in  = 1'b1;
        ok_out = 1'b1;
        for (int d = 0; d < DIGITS; d++) begin
            if (a_i[d*NIBBLE_W +: NIBBLE_W] > 4'd9) ok_in = 1'b0;
            if (b_i[d*NIBBLE_W +: NIBBLE_W] > 4'd9) ok_in = 1'b0;
            if (sum_o[d*NIBBLE_W +: NIBBLE_W] > 4'd9) ok_out = 1'b0;
        end
        if (dec_i === 1'b1 && ok_in === 1'b1) begin
            a_r3_bcd_digits: assert (ok_out !== 1'b0)
                else $error("decimal add produced a non-BCD digit");
        end
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] and_o,
    output logic [DATA_W-1:0] shl_o,
    output logic              shl_cout_o
);

    assign and_o      = a_i & b_i;
    assign shl_o      = {a_i[DATA_W-2:0], 1'b0};
    assign shl_cout_o = a_i[DATA_W-1];

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [1:0]        op_sel,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] mem_in,
    input  logic              carry_in,
    input  logic              dec_mode,
    output logic [DATA_W-1:0] acc_q,
    output logic              n_q,
    output logic              v_q,
    output logic              z_q,
    output logic              c_q
);

    alu_op_e           op;
    alu_flags_t        flg_q;
    alu_flags_t        flg_d;
    logic [DATA_W-1:0] acc_d;

    logic [DATA_W-1:0] add_sum;
    logic              add_c;
    logic              add_v;
    logic [DATA_W-1:0] and_res;
    logic [DATA_W-1:0] shl_res;
    logic              shl_c;

    assign op = alu_op_e'(op_sel);

    alu8_adder #(.DATA_W(DATA_W)) u_adder (
        .a_i    (acc_in),
        .b_i    (mem_in),
        .cin_i  (carry_in),
        .dec_i  (dec_mode),
        .sum_o  (add_sum),
        .cout_o (add_c),
        .ovf_o  (add_v)
    );

    alu8_logic #(.DATA_W(DATA_W)) u_logic (
        .a_i        (acc_in),
        .b_i        (mem_in),
        .and_o      (and_res),
        .shl_o      (shl_res),
        .shl_cout_o (shl_c)
    );

    // Next-state selection: each operation owns its own flag subset.
    always_comb begin
        acc_d = acc_q;
        flg_d = flg_q;
        unique case (op)
            OP_ADD: begin
                acc_d   = add_sum;
                flg_d.c = add_c;
                flg_d.v = add_v;
                flg_d.n = add_sum[DATA_W-1];
                flg_d.z = (add_sum == '0);
            end
            OP_AND: begin
                acc_d   = and_res;
                flg_d.n = and_res[DATA_W-1];
                flg_d.z = (and_res == '0);
            end
            OP_SHL: begin
                acc_d   = shl_res;
                flg_d.c = shl_c;
                flg_d.n = shl_res[DATA_W-1];
                flg_d.z = (shl_res == '0);
            end
            OP_HOLD: begin
                acc_d = acc_q;
                flg_d = flg_q;
            end
            default: begin
                acc_d = acc_q;
                flg_d = flg_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            flg_q <= '0;
        end else if (en) begin
            acc_q <= acc_d;
            flg_q <= flg_d;
        end
    end

    assign n_q = flg_q.n;
    assign v_q = flg_q.v;
    assign z_q = flg_q.z;
    assign c_q = flg_q.c;

    // R9
    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (acc_q == '0) && (flg_q == '0));

    // R8
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(acc_q) && $stable(flg_q));

    // R7
    a_r7_hold_code: assert property (@(posedge clk) disable iff (rst)
        (en && op_sel == 2'b11) |=> $stable(acc_q) && $stable(flg_q));

    // R5
    a_r5_and_keeps_cv: assert property (@(posedge clk) disable iff (rst)
        (en && op_sel == 2'b01) |=> $stable(c_q) && $stable(v_q));

    // R6
    a_r6_shift_carry: assert property (@(posedge clk) disable iff (rst)
        (en && op_sel == 2'b10) |=> (c_q == $past(acc_in[DATA_W-1]))
                                 && !acc_q[0] && $stable(v_q));

    // R4
    a_r4_zero_tracks: assert property (@(posedge clk) disable iff (rst)
        (en && op_sel != 2'b11) |=> (z_q == (acc_q == '0))
                                 && (n_q == acc_q[DATA_W-1]));

endmodule

// File: tb/alu8_core_tb.sv
`timescale 1ns/1ps
module alu8_core_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [1:0] op_sel = 2'b11;
    logic [7:0] acc_in = 8'h00;
    logic [7:0] mem_in = 8'h00;
    logic       carry_in = 1'b0;
    logic       dec_mode = 1'b0;
    logic [7:0] acc_q;
    logic       n_q, v_q, z_q, c_q;

    int checks = 0;
    int errors = 0;

    int m_acc = 0;
    int m_n = 0, m_v = 0, m_z = 0, m_c = 0;

    always #2 clk = ~clk;

    alu8_core u_dut (
        .clk(clk), .rst(rst), .en(en), .op_sel(op_sel),
        .acc_in(acc_in), .mem_in(mem_in), .carry_in(carry_in),
        .dec_mode(dec_mode), .acc_q(acc_q), .n_q(n_q), .v_q(v_q),
        .z_q(z_q), .c_q(c_q)
    );

    function automatic int to_bcd_val(input int x);
        return (x / 16) * 10 + (x % 16);
    endfunction

    task automatic step(input logic r, input logic e, input logic [1:0] o,
                        input int a, input int m, input int ci, input int d);
        string tag;
        int res;
        int tot;
        rst = r; en = e; op_sel = o;
        acc_in = a[7:0]; mem_in = m[7:0]; carry_in = ci[0]; dec_mode = d[0];
        if (r) begin
            tag = "R9";
            m_acc = 0; m_n = 0; m_v = 0; m_z = 0; m_c = 0;
        end else if (!e) begin
            tag = "R8";
        end else if (o == 2'b11) begin
            tag = "R7";
        end else if (o == 2'b10) begin
            tag = "R6 R4";
            res = (a * 2) % 256;
            m_c = (a >= 128) ? 1 : 0;
            m_acc = res; m_n = res / 128; m_z = (res == 0) ? 1 : 0;
        end else if (o == 2'b01) begin
            tag = "R5 R4";
            res = a & m;
            m_acc = res; m_n = res / 128; m_z = (res == 0) ? 1 : 0;
        end else begin
            tot = (a + m + ci) % 256;
            m_v = ((~(a ^ m) & (a ^ tot)) >> 7) & 1;
            if (d != 0) begin
                tag = "R3 R2 R4";
                tot = to_bcd_val(a) + to_bcd_val(m) + ci;
                m_c = (tot > 99) ? 1 : 0;
                tot = tot % 100;
                res = (tot / 10) * 16 + (tot % 10);
            end else begin
                tag = "R1 R2 R4";
                m_c = ((a + m + ci) > 255) ? 1 : 0;
                res = (a + m + ci) % 256;
            end
            m_acc = res; m_n = res / 128; m_z = (res == 0) ? 1 : 0;
        end
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (int'(acc_q) != m_acc || int'(n_q) != m_n || int'(v_q) != m_v
            || int'(z_q) != m_z || int'(c_q) != m_c) begin
            errors++;
            $display("FAIL %s: actual acc=%02h nvzc=%0d%0d%0d%0d expected acc=%02h nvzc=%0d%0d%0d%0d",
                     tag, acc_q, n_q, v_q, z_q, c_q, m_acc[7:0], m_n, m_v, m_z, m_c);
        end
    endtask

    function automatic int rand_bcd();
        return (($urandom % 10) * 16) + ($urandom % 10);
    endfunction

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(1, 0, 2'b00, 8'h12, 8'h34, 1, 0);               // R9 reset state
        step(0, 1, 2'b00, 8'h50, 8'h50, 0, 0);               // R2 overflow, N set
        step(0, 1, 2'b01, 8'hF0, 8'h0F, 0, 0);               // R5 zero, C/V kept
        step(0, 1, 2'b00, 8'hFF, 8'h00, 1, 0);               // R1 wrap: C and Z
        step(0, 1, 2'b01, 8'hC3, 8'h81, 0, 0);               // R5 C stays 1
        step(0, 1, 2'b00, 8'h99, 8'h01, 0, 1);               // R3 99+1 -> 00 C
        step(0, 1, 2'b00, 8'h45, 8'h55, 0, 1);               // R3 both digits
        step(0, 1, 2'b00, 8'h09, 8'h01, 0, 1);               // R3 low digit only
        step(0, 1, 2'b00, 8'h58, 8'h46, 1, 1);               // R3 105 -> 05 C
        step(0, 1, 2'b00, 8'h50, 8'h50, 0, 0);               // set V for R6
        step(0, 1, 2'b10, 8'h80, 8'h00, 0, 0);               // R6 80 -> 00 C Z, V kept
        step(0, 1, 2'b10, 8'hEE, 8'h00, 0, 0);               // R6 EE -> DC
        step(0, 1, 2'b10, 8'h40, 8'h00, 0, 0);               // R6 sign not kept
        step(0, 1, 2'b11, 8'hFF, 8'hFF, 1, 0);               // R7 hold code
        step(0, 0, 2'b00, 8'h01, 8'h01, 0, 0);               // R8 enable low
        step(0, 0, 2'b10, 8'hFF, 8'h00, 0, 0);               // R8 enable low
        for (int i = 0; i < 3000; i++) begin
            int dd = $urandom % 2;
            int aa = dd ? rand_bcd() : int'($urandom % 256);
            int mm = dd ? rand_bcd() : int'($urandom % 256);
            logic [1:0] oo = 2'($urandom % 4);
            logic ee = ($urandom % 8) != 0;
            logic rr = (i == 1500);
            step(rr, ee, oo, aa, mm, int'($urandom % 2), dd);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule